// File: doc/BRIEF.md
# Outstanding Line Miss Tracker

This block keeps a small file of outstanding cache-line misses. A request names a byte address, a target tag and a flag that says whether the line should be kept in the local cache when its data returns. The line part of the address is compared against every live entry in one step. On a miss, the request takes the lowest-numbered free entry. On a hit, the request joins the existing entry as one more target. A running sequence number stamps each new entry, and the entry chosen to go downstream is the oldest one not yet sent.

The keep-line flag of an entry is set from its first request. Each request that joins later can only raise it, never clear it. So the line is kept if any of its waiting requesters asked for it. When the fill controller names an entry as filled, the block shows it the entry's flag, its line address and its ordered target list, all in the same cycle. The entry is released at the following clock edge.

Two stall outputs tell the requester to hold back. One is asserted while every entry is in use. The other is asserted while some entry has all of its target slots filled. An entry opened for an uncacheable access never accepts a second target.

Top module: `mshr_file`

## Requirements
- R1: After reset, no entry is live: `blocked_full`, `blocked_tgts`, `iss_valid` and `look_hit` are all 0.
- R2: When a request misses and a free entry exists, it is accepted (`req_taken`=1, `req_merged`=0). It takes the lowest-numbered free entry (`req_idx`) and stores the address with its low LINE_OFS bits cleared. It opens with one target in slot 0.
- R3: `look_hit` and `look_idx` report, in the same cycle, whether the line of `req_addr` matches a live entry and which one. They ignore the low LINE_OFS bits and do not depend on `req_valid`.
- R4: A request that hits a cacheable entry holding fewer than MAX_TGT targets is merged (`req_taken`=1, `req_merged`=1, `req_idx` = that entry). Its tag goes into the next free target slot; slot k occupies bits [k*TID_W +: TID_W] of `fill_tgts`.
- R5: An entry's keep-line flag equals the OR of the flags of all requests that opened it or merged into it. A merge with flag 0 never clears it.
- R6: `blocked_full` is 1 exactly while all NUM_ENTRIES entries are live. While it is 1, a request to a new line is not accepted.
- R7: `blocked_tgts` is 1 while any live entry holds MAX_TGT targets. A further request to that line is not accepted and changes neither its count nor its flag. Requests to other lines are unaffected.
- R8: A request whose line matches an entry opened for an uncacheable access is not accepted; that entry keeps a single target.
- R9: A newly opened entry starts not in service and becomes an issue candidate on the next cycle.
- R10: `iss_valid`/`iss_idx`/`iss_addr` name the oldest live entry (by sequence number) that is not in service. `iss_ack` with `iss_valid` marks that entry in service, removing it from candidacy.
- R11: With `fill_valid`, the outputs `fill_alloc`, `fill_addr`, `fill_cnt` and `fill_tgts` show entry `fill_idx` in the same cycle, and the entry becomes free at the next edge. The stall outputs reflect the release from the next cycle on. A request hitting the entry being filled in that cycle is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_tid | input | TID_W | Target tag of the requester |
| req_alloc | input | 1 | Keep-line flag of this request |
| req_uncache | input | 1 | Request is uncacheable |
| look_hit | output | 1 | Line of req_addr matches a live entry |
| look_idx | output | IDX_W | Matching entry |
| req_taken | output | 1 | Request accepted this cycle |
| req_merged | output | 1 | Accepted request joined an existing entry |
| req_idx | output | IDX_W | Entry opened or joined |
| blocked_full | output | 1 | Every entry is live |
| blocked_tgts | output | 1 | Some live entry has all target slots used |
| iss_valid | output | 1 | An entry waits to go downstream |
| iss_idx | output | IDX_W | Oldest waiting entry |
| iss_addr | output | ADDR_W | Line address of that entry |
| iss_ack | input | 1 | Downstream took the offered entry |
| fill_valid | input | 1 | Fill completed for entry fill_idx |
| fill_idx | input | IDX_W | Entry being filled |
| fill_alloc | output | 1 | Keep-line flag of the filled entry |
| fill_addr | output | ADDR_W | Line address of the filled entry |
| fill_cnt | output | CNT_W | Number of targets of the filled entry |
| fill_tgts | output | MAX_TGT*TID_W | Target tags of the filled entry, slot 0 lowest |

## Verification
Several properties are checked on every cycle against the per-entry state:
- the keep-line flag of a live entry never falls;
- target counts stay between one and MAX_TGT;
- a fresh entry opens out of service with one target;
- an uncacheable entry never grows beyond one target;
- no new line is accepted while the file is full;
- the issue pointer only ever names a live, waiting entry.

Only the bench scenarios can show that the chosen entry is the oldest rather than the lowest-numbered one, that target tags land in arrival order, that line alignment is applied, and that a fill racing a merge to the same entry rejects the merge.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  typedef enum logic [1:0] {
    REQ_IDLE   = 2'd0,
    REQ_OPEN   = 2'd1,
    REQ_JOIN   = 2'd2,
    REQ_REFUSE = 2'd3
  } req_kind_e;

  // True when sequence number a was issued before b, with wrap-around,
  // for sequence numbers of width w (w <= 32).
  function automatic logic seq_before(input logic [31:0] a,
                                      input logic [31:0] b,
                                      input int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

endpackage

// File: rtl/mshr_slot.sv
module mshr_slot #(
  parameter int LINE_W  = 12,
  parameter int ORDER_W = 6,
  parameter int TID_W   = 4,
  parameter int MAX_TGT = 3,
  parameter int CNT_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     do_open,
  input  logic                     do_join,
  input  logic                     do_issue,
  input  logic                     do_free,
  input  logic [LINE_W-1:0]        in_line,
  input  logic [ORDER_W-1:0]       in_order,
  input  logic [TID_W-1:0]         in_tid,
  input  logic                     in_alloc,
  input  logic                     in_unc,
  output logic                     valid,
  output logic [LINE_W-1:0]        line,
  output logic [ORDER_W-1:0]       order,
  output logic                     alloc,
  output logic                     unc,
  output logic                     insvc,
  output logic [CNT_W-1:0]         cnt,
  output logic [MAX_TGT*TID_W-1:0] tgts
);

  logic [TID_W-1:0] tgt_q [MAX_TGT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      line  <= '0;
      order <= '0;
      alloc <= 1'b0;
      unc   <= 1'b0;
      insvc <= 1'b0;
      cnt   <= '0;
      for (int k = 0; k < MAX_TGT; k++) tgt_q[k] <= '0;
    end else if (do_free) begin
      valid <= 1'b0;
      insvc <= 1'b0;
      cnt   <= '0;
      alloc <= 1'b0;
      unc   <= 1'b0;
    end else if (do_open) begin
      valid <= 1'b1;
      line  <= in_line;
      order <= in_order;
      alloc <= in_alloc;
      unc   <= in_unc;
      insvc <= 1'b0;
      cnt   <= CNT_W'(1);
      for (int k = 0; k < MAX_TGT; k++) tgt_q[k] <= (k == 0) ? in_tid : '0;
    end else begin
      if (do_join) begin
        for (int k = 0; k < MAX_TGT; k++)
          if (cnt == CNT_W'(k)) tgt_q[k] <= in_tid;
        cnt   <= cnt + CNT_W'(1);
        alloc <= alloc | in_alloc;
      end
      if (do_issue) insvc <= 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < MAX_TGT; k++) tgts[k*TID_W +: TID_W] = tgt_q[k];
  end

endmodule

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int N      = 4,
  parameter int LINE_W = 12,
  parameter int IDX_W  = 2
) (
  input  logic [N-1:0]        valid,
  input  logic [N*LINE_W-1:0] lines,
  input  logic [LINE_W-1:0]   probe,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);

  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = valid[i] && (lines[i*LINE_W +: LINE_W] == probe);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int N       = 4,
  parameter int ORDER_W = 6,
  parameter int IDX_W   = 2
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0]         insvc,
  input  logic [N*ORDER_W-1:0] orders,
  output logic                 free_any,
  output logic [IDX_W-1:0]     free_idx,
  output logic                 iss_any,
  output logic [IDX_W-1:0]     iss_idx
);

  import mshr_pkg::*;

  logic [N-1:0]       cand;
  logic [ORDER_W-1:0] best;

  assign cand = valid & ~insvc;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    iss_any = 1'b0;
    iss_idx = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!iss_any ||
          seq_before(32'(orders[i*ORDER_W +: ORDER_W]), 32'(best), ORDER_W))) begin
        iss_any = 1'b1;
        iss_idx = IDX_W'(i);
        best    = orders[i*ORDER_W +: ORDER_W];
      end
    end
  end

endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int NUM_ENTRIES = 4,
  parameter int MAX_TGT     = 3,
  parameter int ADDR_W      = 16,
  parameter int LINE_OFS    = 4,
  parameter int ORDER_W     = 6,
  parameter int TID_W       = 4,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNT_W      = $clog2(MAX_TGT + 1),
  localparam int LINE_W     = ADDR_W - LINE_OFS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [TID_W-1:0]         req_tid,
  input  logic                     req_alloc,
  input  logic                     req_uncache,
  output logic                     look_hit,
  output logic [IDX_W-1:0]         look_idx,
  output logic                     req_taken,
  output logic                     req_merged,
  output logic [IDX_W-1:0]         req_idx,
  output logic                     blocked_full,
  output logic                     blocked_tgts,
  output logic                     iss_valid,
  output logic [IDX_W-1:0]         iss_idx,
  output logic [ADDR_W-1:0]        iss_addr,
  input  logic                     iss_ack,
  input  logic                     fill_valid,
  input  logic [IDX_W-1:0]         fill_idx,
  output logic                     fill_alloc,
  output logic [ADDR_W-1:0]        fill_addr,
  output logic [CNT_W-1:0]         fill_cnt,
  output logic [MAX_TGT*TID_W-1:0] fill_tgts
);

  import mshr_pkg::*;

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return LINE_W'(a >> LINE_OFS);
  endfunction

  function automatic logic [ADDR_W-1:0] base_of(input logic [LINE_W-1:0] l);
    return ADDR_W'(l) << LINE_OFS;
  endfunction

  // Per-entry state brought out as named wires.
  logic [NUM_ENTRIES-1:0]               ent_valid;
  logic [NUM_ENTRIES-1:0]               ent_alloc;
  logic [NUM_ENTRIES-1:0]               ent_unc;
  logic [NUM_ENTRIES-1:0]               ent_insvc;
  logic [NUM_ENTRIES*CNT_W-1:0]         ent_cnt;
  logic [NUM_ENTRIES*LINE_W-1:0]        ent_line;
  logic [NUM_ENTRIES*ORDER_W-1:0]       ent_order;
  logic [NUM_ENTRIES*MAX_TGT*TID_W-1:0] ent_tgts;

  // Internal events.
  logic [NUM_ENTRIES-1:0] ev_open, ev_join, ev_issue, ev_free;
  logic [NUM_ENTRIES-1:0] ent_at_max;

  logic [LINE_W-1:0]  probe_line;
  logic               free_any, iss_any;
  logic [IDX_W-1:0]   free_idx, pick_idx;
  logic [ORDER_W-1:0] seq_q;
  logic [CNT_W-1:0]   hit_cnt;
  logic               hit_unc;
  logic               fill_clash;
  req_kind_e          kind;

  assign probe_line = line_of(req_addr);

  mshr_match #(.N(NUM_ENTRIES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_match (
    .valid (ent_valid),
    .lines (ent_line),
    .probe (probe_line),
    .hit   (look_hit),
    .idx   (look_idx)
  );

  mshr_pick #(.N(NUM_ENTRIES), .ORDER_W(ORDER_W), .IDX_W(IDX_W)) u_pick (
    .valid    (ent_valid),
    .insvc    (ent_insvc),
    .orders   (ent_order),
    .free_any (free_any),
    .free_idx (free_idx),
    .iss_any  (iss_any),
    .iss_idx  (pick_idx)
  );

  // Request decision.
  assign hit_cnt    = ent_cnt[look_idx*CNT_W +: CNT_W];
  assign hit_unc    = ent_unc[look_idx];
  assign fill_clash = fill_valid && (fill_idx == look_idx);

  always_comb begin
    if (!req_valid)
      kind = REQ_IDLE;
    else if (look_hit)
      kind = (!hit_unc && (hit_cnt < CNT_W'(MAX_TGT)) && !fill_clash) ? REQ_JOIN : REQ_REFUSE;
    else
      kind = free_any ? REQ_OPEN : REQ_REFUSE;
  end

  assign req_taken  = (kind == REQ_OPEN) || (kind == REQ_JOIN);
  assign req_merged = (kind == REQ_JOIN);
  assign req_idx    = (kind == REQ_JOIN) ? look_idx : free_idx;

  // Sequence stamp for new entries.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= '0;
    else if (kind == REQ_OPEN) seq_q <= seq_q + ORDER_W'(1);
  end

  // Entry storage.
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    assign ev_open[i]  = (kind == REQ_OPEN) && (free_idx == IDX_W'(i));
    assign ev_join[i]  = (kind == REQ_JOIN) && (look_idx == IDX_W'(i));
    assign ev_issue[i] = iss_ack && iss_any && (pick_idx == IDX_W'(i));
    assign ev_free[i]  = fill_valid && (fill_idx == IDX_W'(i));
    assign ent_at_max[i] = ent_valid[i] &&
                           (ent_cnt[i*CNT_W +: CNT_W] == CNT_W'(MAX_TGT));

    mshr_slot #(
      .LINE_W(LINE_W), .ORDER_W(ORDER_W), .TID_W(TID_W),
      .MAX_TGT(MAX_TGT), .CNT_W(CNT_W)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_open  (ev_open[i]),
      .do_join  (ev_join[i]),
      .do_issue (ev_issue[i]),
      .do_free  (ev_free[i]),
      .in_line  (probe_line),
      .in_order (seq_q),
      .in_tid   (req_tid),
      .in_alloc (req_alloc),
      .in_unc   (req_uncache),
      .valid    (ent_valid[i]),
      .line     (ent_line[i*LINE_W +: LINE_W]),
      .order    (ent_order[i*ORDER_W +: ORDER_W]),
      .alloc    (ent_alloc[i]),
      .unc      (ent_unc[i]),
      .insvc    (ent_insvc[i]),
      .cnt      (ent_cnt[i*CNT_W +: CNT_W]),
      .tgts     (ent_tgts[i*MAX_TGT*TID_W +: MAX_TGT*TID_W])
    );
  end

  // Stall indications.
  assign blocked_full = &ent_valid;
  assign blocked_tgts = |ent_at_max;

  // Issue side.
  assign iss_valid = iss_any;
  assign iss_idx   = pick_idx;
  assign iss_addr  = base_of(ent_line[pick_idx*LINE_W +: LINE_W]);

  // Fill side.
  assign fill_alloc = ent_alloc[fill_idx];
  assign fill_addr  = base_of(ent_line[fill_idx*LINE_W +: LINE_W]);
  assign fill_cnt   = ent_cnt[fill_idx*CNT_W +: CNT_W];
  assign fill_tgts  = ent_tgts[fill_idx*MAX_TGT*TID_W +: MAX_TGT*TID_W];

endmodule

// File: rtl/mshr_file_sva.sv
module mshr_file_sva #(
  parameter int N       = 4,
  parameter int MAX_TGT = 3,
  parameter int CNT_W   = 2,
  parameter int IDX_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     ent_valid,
  input logic [N-1:0]     ent_alloc,
  input logic [N-1:0]     ent_unc,
  input logic [N-1:0]     ent_insvc,
  input logic [N*CNT_W-1:0] ent_cnt,
  input logic             blocked_full,
  input logic             req_taken,
  input logic             req_merged,
  input logic             iss_valid,
  input logic [IDX_W-1:0] iss_idx
);

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid[i] && $past(ent_valid[i]) && $past(ent_alloc[i])) |-> ent_alloc[i]); // R5

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[i] |-> (ent_cnt[i*CNT_W +: CNT_W] >= CNT_W'(1) &&
                        ent_cnt[i*CNT_W +: CNT_W] <= CNT_W'(MAX_TGT))); // R7

    AST_FRESH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ent_valid[i]) |-> (!ent_insvc[i] && ent_cnt[i*CNT_W +: CNT_W] == CNT_W'(1))); // R9

    AST_UNCACHED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_valid[i] && ent_unc[i]) |-> ent_cnt[i*CNT_W +: CNT_W] == CNT_W'(1)); // R8
  end

  AST_FULL_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_full |-> !(req_taken && !req_merged)); // R6

  AST_ISSUE_LIVE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (ent_valid[iss_idx] && !ent_insvc[iss_idx])); // R10

endmodule

bind mshr_file mshr_file_sva #(
  .N(NUM_ENTRIES), .MAX_TGT(MAX_TGT), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .ent_valid    (ent_valid),
  .ent_alloc    (ent_alloc),
  .ent_unc      (ent_unc),
  .ent_insvc    (ent_insvc),
  .ent_cnt      (ent_cnt),
  .blocked_full (blocked_full),
  .req_taken    (req_taken),
  .req_merged   (req_merged),
  .iss_valid    (iss_valid),
  .iss_idx      (iss_idx)
);

// File: tb/mshr_file_tb.sv
`timescale 1ns/1ps
module mshr_file_tb;

  localparam int NE = 4, MT = 3, AW = 16, LO = 4, OW = 6, TW = 4;
  localparam int IW = 2, CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tid = '0;
  logic req_alloc = 1'b0, req_uncache = 1'b0;
  logic look_hit, req_taken, req_merged, blocked_full, blocked_tgts, iss_valid;
  logic [IW-1:0] look_idx, req_idx, iss_idx;
  logic [AW-1:0] iss_addr, fill_addr;
  logic iss_ack = 1'b0, fill_valid = 1'b0;
  logic [IW-1:0] fill_idx = '0;
  logic fill_alloc;
  logic [CW-1:0] fill_cnt;
  logic [MT*TW-1:0] fill_tgts;

  int n_chk = 0, n_bad = 0;

  // captured results
  logic c_taken, c_merged;
  logic [IW-1:0] c_idx;
  logic c_alloc;
  logic [CW-1:0] c_cnt;
  logic [MT*TW-1:0] c_tgts;
  logic [AW-1:0] c_addr;

  always #4 clk = ~clk;

  mshr_file #(.NUM_ENTRIES(NE), .MAX_TGT(MT), .ADDR_W(AW), .LINE_OFS(LO),
              .ORDER_W(OW), .TID_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_tid(req_tid), .req_alloc(req_alloc), .req_uncache(req_uncache),
    .look_hit(look_hit), .look_idx(look_idx), .req_taken(req_taken),
    .req_merged(req_merged), .req_idx(req_idx), .blocked_full(blocked_full),
    .blocked_tgts(blocked_tgts), .iss_valid(iss_valid), .iss_idx(iss_idx),
    .iss_addr(iss_addr), .iss_ack(iss_ack), .fill_valid(fill_valid),
    .fill_idx(fill_idx), .fill_alloc(fill_alloc), .fill_addr(fill_addr),
    .fill_cnt(fill_cnt), .fill_tgts(fill_tgts)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [TW-1:0] t,
                      input logic al, input logic un);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_tid = t; req_alloc = al; req_uncache = un;
    #2;
    c_taken = req_taken; c_merged = req_merged; c_idx = req_idx;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [IW-1:0] i);
    @(negedge clk);
    fill_valid = 1'b1; fill_idx = i;
    #2;
    c_alloc = fill_alloc; c_cnt = fill_cnt; c_tgts = fill_tgts; c_addr = fill_addr;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic issue(input logic [IW-1:0] exp_idx, input string req);
    @(negedge clk);
    #2;
    chk(req, {31'd0, iss_valid}, 32'd1);
    chk(req, 32'(iss_idx), 32'(exp_idx));
    iss_ack = 1'b1;
    @(posedge clk); #1;
    iss_ack = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); req_addr = 16'h1230; #2;
    chk("R1 full", {31'd0, blocked_full}, 0);
    chk("R1 tgts", {31'd0, blocked_tgts}, 0);
    chk("R1 iss", {31'd0, iss_valid}, 0);
    chk("R1 hit", {31'd0, look_hit}, 0);
  endtask

  task automatic t_open_merge;
    send(16'h1234, 4'd1, 1'b0, 1'b0);
    chk("R2 taken", {31'd0, c_taken}, 1);
    chk("R2 merged", {31'd0, c_merged}, 0);
    chk("R2 idx", 32'(c_idx), 0);
    @(negedge clk); req_addr = 16'h123F; #2;
    chk("R3 hit", {31'd0, look_hit}, 1);
    chk("R3 idx", 32'(look_idx), 0);
    req_addr = 16'h1244; #1;
    chk("R3 other line", {31'd0, look_hit}, 0);
    chk("R9 candidate", {31'd0, iss_valid}, 1);
    chk("R9 addr", 32'(iss_addr), 32'h1230);
    send(16'h1238, 4'd2, 1'b1, 1'b0);
    chk("R4 merged", {31'd0, c_merged}, 1);
    chk("R4 idx", 32'(c_idx), 0);
    issue(0, "R10 single");
    @(negedge clk); #2;
    chk("R10 none left", {31'd0, iss_valid}, 0);
    fill(0);
    chk("R5 flag or", {31'd0, c_alloc}, 1);
    chk("R4 cnt", 32'(c_cnt), 2);
    chk("R4 tgts", 32'(c_tgts), 32'h021);
    chk("R11 addr", 32'(c_addr), 32'h1230);
    @(negedge clk); req_addr = 16'h1230; #2;
    chk("R11 freed", {31'd0, look_hit}, 0);
  endtask

  task automatic t_no_downgrade;
    send(16'h2000, 4'd3, 1'b1, 1'b0);
    send(16'h2004, 4'd4, 1'b0, 1'b0);
    chk("R4 join", {31'd0, c_merged}, 1);
    fill(0);
    chk("R5 kept", {31'd0, c_alloc}, 1);
  endtask

  task automatic t_targets;
    send(16'h3000, 4'd1, 1'b0, 1'b0);
    send(16'h3004, 4'd2, 1'b0, 1'b0);
    @(negedge clk); #2;
    chk("R7 not yet", {31'd0, blocked_tgts}, 0);
    send(16'h3008, 4'd3, 1'b0, 1'b0);
    @(negedge clk); #2;
    chk("R7 blocked", {31'd0, blocked_tgts}, 1);
    send(16'h300C, 4'd4, 1'b1, 1'b0);
    chk("R7 refused", {31'd0, c_taken}, 0);
    send(16'h3100, 4'd5, 1'b0, 1'b0);
    chk("R7 other line", {31'd0, c_taken}, 1);
    chk("R7 other idx", 32'(c_idx), 1);
    fill(0);
    chk("R7 cnt", 32'(c_cnt), 3);
    chk("R7 flag", {31'd0, c_alloc}, 0);
    chk("R4 order", 32'(c_tgts), 32'h321);
    @(negedge clk); #2;
    chk("R11 tgts clear", {31'd0, blocked_tgts}, 0);
    fill(1);
  endtask

  task automatic t_full_order;
    send(16'h4000, 4'd1, 1'b0, 1'b0);
    send(16'h4100, 4'd2, 1'b0, 1'b0);
    send(16'h4200, 4'd3, 1'b0, 1'b0);
    send(16'h4300, 4'd4, 1'b0, 1'b0);
    chk("R2 idx3", 32'(c_idx), 3);
    @(negedge clk); #2;
    chk("R6 full", {31'd0, blocked_full}, 1);
    send(16'h4400, 4'd5, 1'b0, 1'b0);
    chk("R6 refused", {31'd0, c_taken}, 0);
    send(16'h4104, 4'd6, 1'b0, 1'b0);
    chk("R6 join ok", {31'd0, c_merged}, 1);
    fill(2);
    @(negedge clk); #2;
    chk("R11 full clear", {31'd0, blocked_full}, 0);
    send(16'h4500, 4'd7, 1'b0, 1'b0);
    chk("R2 lowest free", 32'(c_idx), 2);
    issue(0, "R10 oldest a");
    issue(1, "R10 oldest b");
    issue(3, "R10 oldest c");
    issue(2, "R10 youngest");
    fill(0); fill(1); fill(2); fill(3);
  endtask

  task automatic t_uncached;
    send(16'h5000, 4'd6, 1'b1, 1'b1);
    chk("R8 open", {31'd0, c_taken}, 1);
    send(16'h5004, 4'd7, 1'b1, 1'b0);
    chk("R8 refused", {31'd0, c_taken}, 0);
    fill(0);
    chk("R8 cnt", 32'(c_cnt), 1);
  endtask

  task automatic t_clash;
    send(16'h6000, 4'd1, 1'b0, 1'b0);
    @(negedge clk);
    fill_valid = 1'b1; fill_idx = 0;
    req_valid = 1'b1; req_addr = 16'h6004; req_tid = 4'd2; req_alloc = 1'b0; req_uncache = 1'b0;
    #2;
    chk("R11 clash", {31'd0, req_taken}, 0);
    @(posedge clk); #1;
    fill_valid = 1'b0; req_valid = 1'b0;
    @(negedge clk); req_addr = 16'h6000; #2;
    chk("R11 gone", {31'd0, look_hit}, 0);
    chk("R11 no iss", {31'd0, iss_valid}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_open_merge();
    t_no_downgrade();
    t_targets();
    t_full_order();
    t_uncached();
    t_clash();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule